// File: doc/BRIEF.md
# One-Hot Controlled Bitwise Logic Register

This block keeps an n-bit accumulator register and, on each clock edge, can replace the register's contents with a bitwise combination of its current value and an operand word. The operation is chosen by three separate one-hot strobes, one each for AND, XOR and OR. When no strobe is raised, the register keeps its value. When more than one strobe is raised in the same cycle, the block treats the cycle as illegal: it raises a flag and leaves the register unchanged.

The register is built from identical single-bit cells. Each cell holds one enabled D flip-flop. Its next value is a sum of products: each strobe gates its own operation result, and the gated terms are ORed together. One shared load enable, the OR of the strobes, opens every cell at once. The controls and the operand are plain level signals sampled on each rising edge. This block has no streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `onehot_logic_reg`

## Requirements
- R1: While rst_n is low at a rising clock edge, acc_q becomes all zeros on that edge, whatever the strobes are.
- R2: If only op_and is high at an edge, acc_q becomes acc_q AND opnd for every bit.
- R3: If only op_xor is high at an edge, acc_q becomes acc_q XOR opnd for every bit.
- R4: If only op_or is high at an edge, acc_q becomes acc_q OR opnd for every bit.
- R5: If no strobe is high at an edge, acc_q does not change, whatever opnd is.
- R6: bad_ctl is a combinational output. It is 1 exactly when two or more of op_and, op_xor and op_or are high in the current cycle.
- R7: If two or more strobes are high at an edge, acc_q does not change.
- R8: The register width is set by the parameter WIDTH, which defaults to 8. Every bit behaves the same way, with no interaction between bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous clear |
| op_and | input | 1 | Strobe that selects the AND operation |
| op_xor | input | 1 | Strobe that selects the XOR operation |
| op_or | input | 1 | Strobe that selects the OR operation |
| opnd | input | WIDTH | Operand word combined with the register |
| acc_q | output | WIDTH | Present contents of the register |
| bad_ctl | output | 1 | High while more than one strobe is asserted |

## Verification
Properties are checked on every cycle. They cover these rules: the next value after each single-strobe edge, the hold on idle and illegal edges, the clear that follows a low reset, and the flag's agreement with the strobe count. Only the bench's scenarios can show the rest. These include whole sequences of mixed operations that build on earlier results, and operand patterns that differ between bits. They also include reset applied while strobes are active and the illegal pairs and triple. In all of these, a behavioural model must agree with the register at every clock.

// File: rtl/onehot_logic_pkg.sv
package onehot_logic_pkg;
  localparam int unsigned NUM_OPS = 3;
  typedef enum logic [1:0] {
    OP_IDX_AND = 2'd0,
    OP_IDX_XOR = 2'd1,
    OP_IDX_OR  = 2'd2
  } op_idx_e;
  typedef struct packed {
    logic do_or;
    logic do_xor;
    logic do_and;
  } op_strobes_t;
endpackage

// File: rtl/op_ctl_decode.sv
module op_ctl_decode
  import onehot_logic_pkg::*;
(
  input  logic        rst_n,
  input  op_strobes_t strobes,
  output op_strobes_t gated,
  output logic        load_en,
  output logic        illegal
);
  logic [NUM_OPS-1:0] vec;
  logic [1:0]         cnt;

  always_comb begin
    vec = strobes;
    cnt = '0;
    for (int i = 0; i < int'(NUM_OPS); i++) cnt = cnt + {1'b0, vec[i]};
  end

  assign illegal = (cnt > 2'd1);
  assign gated   = illegal ? '0 : strobes;
  assign load_en = (|gated) || !rst_n;
endmodule

// File: rtl/logic_bit_cell.sv
module logic_bit_cell
  import onehot_logic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_en,
  input  op_strobes_t sel,
  input  logic        b_in,
  output logic        a_q
);
  logic d_in;

  always_comb begin
    d_in = (sel.do_and & a_q & b_in)
         | (sel.do_xor & (a_q ^ b_in))
         | (sel.do_or  & (a_q | b_in));
    if (!rst_n) d_in = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load_en) a_q <= d_in;
  end
endmodule

// File: rtl/onehot_logic_reg.sv
module onehot_logic_reg
  import onehot_logic_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_and,
  input  logic             op_xor,
  input  logic             op_or,
  input  logic [WIDTH-1:0] opnd,
  output logic [WIDTH-1:0] acc_q,
  output logic             bad_ctl
);
  localparam int unsigned LAST_BIT = WIDTH - 1;

  op_strobes_t raw_sel, cell_sel;
  logic        load_en;

  assign raw_sel = '{do_or: op_or, do_xor: op_xor, do_and: op_and};

  op_ctl_decode u_dec (
    .rst_n   (rst_n),
    .strobes (raw_sel),
    .gated   (cell_sel),
    .load_en (load_en),
    .illegal (bad_ctl)
  );

  for (genvar g = 0; g <= LAST_BIT; g++) begin : g_cell
    logic_bit_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (load_en),
      .sel     (cell_sel),
      .b_in    (opnd[g]),
      .a_q     (acc_q[g])
    );
  end

  logic seen_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_rst <= 1'b1;
    else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
  end

  p_clear_r1: assert property (@(posedge clk) seen_rst === 1'b1 && !rst_n |=> acc_q == '0);
  p_and_r2: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
    op_and && !op_xor && !op_or |=> acc_q == ($past(acc_q) & $past(opnd)));
  p_xor_r3: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
    !op_and && op_xor && !op_or |=> acc_q == ($past(acc_q) ^ $past(opnd)));
  p_or_r4: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
    !op_and && !op_xor && op_or |=> acc_q == ($past(acc_q) | $past(opnd)));
  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
    !op_and && !op_xor && !op_or |=> $stable(acc_q));
  p_flag_r6: assert property (@(posedge clk)
    bad_ctl == ($countones({op_and, op_xor, op_or}) > 1));
  p_illegal_hold_r7: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
    $countones({op_and, op_xor, op_or}) > 1 |=> $stable(acc_q));
endmodule

// File: tb/test_onehot_logic_reg.sv
module test_onehot_logic_reg;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, op_and = 0, op_xor = 0, op_or = 0;
  logic [W-1:0] opnd = '0;
  logic [W-1:0] acc_q;
  logic bad_ctl;
  int checks = 0, errors = 0;
  logic [W-1:0] model = '0;
  bit done = 0;

  always #2 clk = ~clk;

  onehot_logic_reg #(.WIDTH(W)) i_onehot_logic_reg (
    .clk(clk), .rst_n(rst_n), .op_and(op_and), .op_xor(op_xor), .op_or(op_or),
    .opnd(opnd), .acc_q(acc_q), .bad_ctl(bad_ctl));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic a, input logic x, input logic o,
                      input logic [W-1:0] b, input string req);
    int n;
    logic [W-1:0] nxt;
    rst_n = r; op_and = a; op_xor = x; op_or = o; opnd = b;
    #1;
    n = int'(a) + int'(x) + int'(o);
    chk("R6 bad_ctl", {{(W-1){1'b0}}, bad_ctl}, {{(W-1){1'b0}}, n > 1});
    if (!r) nxt = '0;
    else if (n != 1) nxt = model;
    else if (a) nxt = model & b;
    else if (x) nxt = model ^ b;
    else nxt = model | b;
    @(posedge clk); #1;
    model = nxt;
    chk(req, acc_q, model);
  endtask

  initial begin
    #1;
    step(0, 0, 0, 0, 8'hFF, "R1 reset");
    step(0, 1, 0, 1, 8'hFF, "R1 reset over strobes");
    step(1, 0, 0, 1, 8'hA5, "R4 or");
    step(1, 0, 1, 0, 8'h3C, "R3 xor");
    step(1, 1, 0, 0, 8'hF0, "R2 and");
    step(1, 0, 0, 0, 8'hFF, "R5 idle");
    step(1, 0, 0, 0, 8'h00, "R5 idle");
    step(1, 1, 1, 0, 8'h00, "R7 and+xor");
    step(1, 0, 1, 1, 8'hFF, "R7 xor+or");
    step(1, 1, 0, 1, 8'h00, "R7 and+or");
    step(1, 1, 1, 1, 8'h55, "R7 all");
    step(1, 0, 0, 1, 8'h81, "R8 edge bits or");
    step(1, 0, 1, 0, 8'hFF, "R8 xor all bits");
    step(1, 0, 0, 1, 8'h00, "R4 or zero");
    step(1, 1, 0, 0, 8'hFF, "R2 and ones");
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] b;
      b = W'((i * 37 + 11) ^ (i << 3));
      case (i % 5)
        0: step(1, 1, 0, 0, b, "R2 sweep");
        1: step(1, 0, 1, 0, b, "R3 sweep");
        2: step(1, 0, 0, 1, b, "R4 sweep");
        3: step(1, 0, 0, 0, b, "R5 sweep");
        default: step(1, 1, 1, 0, b, "R7 sweep");
      endcase
    end
    step(0, 0, 1, 0, 8'hFF, "R1 mid-run reset");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); errors++; checks++; $display("FAIL watchdog expired"); end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule